// File: doc/BRIEF.md
# General-Purpose Strobe Port Controller

This block sits on an 8/16-bit I/O bus behind an indexed register file and gives each of two sockets a general-purpose strobe pin. Software writes a register number to an index port and then reaches that register through a data port. One register slot per socket is an "external data" window. When the socket is configured for it, a bus write or read of that window pulses the socket's strobe pin. An external latch or buffer can then capture the data from the bus or put data onto it, and the external port behaves like an ordinary register.

Each socket holds an extended-index register, a strobe control register and an 8-bit shadow of the last byte written to its external-data window. The control register picks write-strobe, read-strobe or both, and chooses push-pull or open-drain pin drive. When the pin is not used as a strobe, its pull-up is enabled. A configuration input chooses whether external data travels on the low or the high byte lane of the bus. The strobes are registered, so each one follows the bus command with a one-cycle delay and never glitches while the address is being decoded.

Top module: `gps_port_ctrl`

## Requirements
- R1: After reset both strobes are high (inactive), no pin is driven, the bus is not driven, the index register, the extended-index registers, the control registers and the shadows are all 0, and the external-data window is not selected (a read of the data port at index 2Fh does not drive the bus).
- R2: With control bit 4 set, a write to data port 3E1h while the socket's external-data window is selected drives the socket's strobe low. The strobe goes low one clock after the write begins and stays low for exactly as many clocks as the write command is held.
- R3: With control bit 3 set, a read of 3E1h under the same selection drives the strobe low for exactly as many clocks as the read command is held, also delayed by one clock.
- R4: A socket's window is selected only when the index register holds its window index (2Fh for socket 0, 6Fh for socket 1) and the socket's extended index is 0Ah. Accesses under any other selection leave that strobe high, and at most one strobe is low at a time.
- R5: With the strobe-enable bit for the access direction clear (bit 4 for writes, bit 3 for reads), accesses to the window leave the strobe high.
- R6: Control bit 2 selects push-pull drive: while the socket is configured as a strobe, its output enable is 1 at all times. With bit 2 clear the drive is open-drain: the output enable is 1 only while the strobe is low. An unconfigured pin is never driven.
- R7: The pull-up enable of a socket is 1 only when neither bit 3 nor bit 4 is set and that socket's pull-up control input is 0.
- R8: Control bits 7:6 and 1:0 are not stored and always read as 0. Writing FFh reads back as 1Ch.
- R9: A read of the window while bit 3 is clear drives the bus with the shadow, which is the last byte written to the window. Read data appears one clock after the read command and the bus is driven only in answer to a read.
- R10: With the wide-bus input at 1, window data is taken from bus bits 15:8 on writes and returned on bits 15:8 (low byte 0) on reads. With it at 0, bits 7:0 are used in both directions.
- R11: With bit 3 set (alone or together with bit 4), the block does not drive the bus on a window read, leaving the data to the external buffer. With both bits set, the pin strobes on both reads and writes.
- R12: The index register is written and read at 3E0h. At index 2Eh (socket 0) or 6Eh (socket 1), the data port accesses the socket's extended-index register. Extended index 0Bh at the window index accesses the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_iow_n | input | 1 | Active-low I/O write command |
| bus_ior_n | input | 1 | Active-low I/O read command |
| bus_din | input | 16 | Write data from the bus |
| bus_dout | output | 16 | Read data to the bus |
| bus_doe | output | 1 | Block drives bus_dout |
| wide_bus | input | 1 | 1: window data on bits 15:8, 0: on bits 7:0 |
| sock_pu_ctl | input | NUM_SOCK | Per-socket pull-up disable control |
| gps_n | output | NUM_SOCK | Active-low strobe level per socket |
| gps_oe | output | NUM_SOCK | Pin output enable per socket |
| gps_pu_en | output | NUM_SOCK | Pin pull-up enable per socket |

## Verification
The assertions check every cycle that a strobe falls only after a bus command, that no two strobes are low together, that an active strobe is always driven, that the pull-up is never on while the pin is driven or strobing, and that the bus is driven only after a read. Only the directed scenarios can show exact pulse lengths, the index and extended-index selection rules, register readback with its reserved bits, shadow contents, lane placement, and the read-release behaviour when the read strobe is enabled.

// File: rtl/gps_pkg.sv
package gps_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] ext;
        logic              wr_en;
        logic              rd_en;
        logic              push_pull;
        logic [BYTE_W-1:0] shadow;
        logic              strb_n;
    } sock_state_t;

    typedef struct packed {
        logic idx_wr;
        logic data_wr;
        logic idx_rd;
        logic data_rd;
    } bus_cmd_t;

    // Control register image: only bits 4:2 exist, the rest read as 0
    function automatic logic [BYTE_W-1:0] ctl_image(logic wr, logic rd, logic pp);
        return {3'b000, wr, rd, pp, 2'b00};
    endfunction

endpackage

// File: rtl/gps_bus_decode.sv
module gps_bus_decode
    import gps_pkg::*;
#(
    parameter int              ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] INDEX_PORT = 10'h3E0,
    parameter logic [ADDR_W-1:0] DATA_PORT  = 10'h3E1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              iow_n,
    input  logic              ior_n,
    output bus_cmd_t          cmd
);

    logic at_index;
    logic at_data;

    always_comb begin
        at_index     = (addr == INDEX_PORT);
        at_data      = (addr == DATA_PORT);
        cmd.idx_wr   = at_index && !iow_n;
        cmd.data_wr  = at_data  && !iow_n;
        cmd.idx_rd   = at_index && !ior_n;
        cmd.data_rd  = at_data  && !ior_n;
    end

endmodule

// File: rtl/gps_socket.sv
module gps_socket
    import gps_pkg::*;
#(
    parameter logic [BYTE_W-1:0] IDX_BASE  = 8'h2E,
    parameter logic [BYTE_W-1:0] XDATA_EXT = 8'h0A,
    parameter logic [BYTE_W-1:0] XCTL_EXT  = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] idx,
    input  logic [BYTE_W-1:0] wbyte_lo,
    input  logic [BYTE_W-1:0] wbyte_lane,
    input  logic              pu_ctl,
    output logic              strb_n,
    output logic              pin_oe,
    output logic              pu_en,
    output logic              rd_hit,
    output logic              rd_xdata,
    output logic              rd_release,
    output logic [BYTE_W-1:0] rd_byte
);

    localparam logic [BYTE_W-1:0] IDX_WIN = IDX_BASE + 8'd1;

    sock_state_t s_q, s_d;
    logic hit_ext, hit_win, sel_x, sel_c, as_strobe;

    always_comb begin
        hit_ext = (idx == IDX_BASE);
        hit_win = (idx == IDX_WIN);
        sel_x   = hit_win && (s_q.ext == XDATA_EXT);
        sel_c   = hit_win && (s_q.ext == XCTL_EXT);

        s_d = s_q;
        if (data_wr) begin
            if (hit_ext) s_d.ext = wbyte_lo;
            if (sel_c) begin
                s_d.wr_en     = wbyte_lo[4];
                s_d.rd_en     = wbyte_lo[3];
                s_d.push_pull = wbyte_lo[2];
            end
            if (sel_x) s_d.shadow = wbyte_lane;
        end
        s_d.strb_n = !(sel_x && ((s_q.wr_en && data_wr) || (s_q.rd_en && data_rd)));

        rd_hit     = hit_ext || sel_c || sel_x;
        rd_xdata   = sel_x;
        rd_release = sel_x && s_q.rd_en;
        if (hit_ext)    rd_byte = s_q.ext;
        else if (sel_c) rd_byte = ctl_image(s_q.wr_en, s_q.rd_en, s_q.push_pull);
        else            rd_byte = s_q.shadow;

        as_strobe = s_q.wr_en || s_q.rd_en;
        strb_n    = s_q.strb_n;
        pin_oe    = as_strobe && (s_q.push_pull || !s_q.strb_n);
        pu_en     = !as_strobe && !pu_ctl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.strb_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/gps_port_ctrl.sv
module gps_port_ctrl
    import gps_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] INDEX_PORT  = 10'h3E0,
    parameter logic [ADDR_W-1:0] DATA_PORT   = 10'h3E1,
    parameter int                NUM_SOCK    = 2,
    parameter logic [7:0]        SOCK_BASE   = 8'h2E,
    parameter logic [7:0]        SOCK_STRIDE = 8'h40,
    parameter logic [7:0]        XDATA_EXT   = 8'h0A,
    parameter logic [7:0]        XCTL_EXT    = 8'h0B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_iow_n,
    input  logic                bus_ior_n,
    input  logic [15:0]         bus_din,
    output logic [15:0]         bus_dout,
    output logic                bus_doe,
    input  logic                wide_bus,
    input  logic [NUM_SOCK-1:0] sock_pu_ctl,
    output logic [NUM_SOCK-1:0] gps_n,
    output logic [NUM_SOCK-1:0] gps_oe,
    output logic [NUM_SOCK-1:0] gps_pu_en
);

    localparam int DATA_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] idx;
        logic [DATA_W-1:0] dout;
        logic              doe;
    } top_state_t;

    bus_cmd_t          cmd;
    top_state_t        t_q, t_d;
    logic [BYTE_W-1:0] wlane;
    logic [NUM_SOCK-1:0] s_hit, s_xdata, s_release;
    logic [BYTE_W-1:0] s_byte [NUM_SOCK];

    gps_bus_decode #(
        .ADDR_W     (ADDR_W),
        .INDEX_PORT (INDEX_PORT),
        .DATA_PORT  (DATA_PORT)
    ) u_decode (
        .addr  (bus_addr),
        .iow_n (bus_iow_n),
        .ior_n (bus_ior_n),
        .cmd   (cmd)
    );

    assign wlane = wide_bus ? bus_din[DATA_W-1:BYTE_W] : bus_din[BYTE_W-1:0];

    for (genvar i = 0; i < NUM_SOCK; i++) begin : g_sock
        gps_socket #(
            .IDX_BASE  (SOCK_BASE + SOCK_STRIDE * 8'(i)),
            .XDATA_EXT (XDATA_EXT),
            .XCTL_EXT  (XCTL_EXT)
        ) u_sock (
            .clk        (clk),
            .rst_n      (rst_n),
            .data_wr    (cmd.data_wr),
            .data_rd    (cmd.data_rd),
            .idx        (t_q.idx),
            .wbyte_lo   (bus_din[BYTE_W-1:0]),
            .wbyte_lane (wlane),
            .pu_ctl     (sock_pu_ctl[i]),
            .strb_n     (gps_n[i]),
            .pin_oe     (gps_oe[i]),
            .pu_en      (gps_pu_en[i]),
            .rd_hit     (s_hit[i]),
            .rd_xdata   (s_xdata[i]),
            .rd_release (s_release[i]),
            .rd_byte    (s_byte[i])
        );
    end

    always_comb begin
        t_d      = t_q;
        t_d.doe  = 1'b0;
        t_d.dout = '0;
        if (cmd.idx_wr) t_d.idx = bus_din[BYTE_W-1:0];
        if (cmd.idx_rd) begin
            t_d.doe  = 1'b1;
            t_d.dout = {{BYTE_W{1'b0}}, t_q.idx};
        end else if (cmd.data_rd) begin
            for (int i = 0; i < NUM_SOCK; i++) begin
                if (s_hit[i] && !s_release[i]) begin
                    t_d.doe  = 1'b1;
                    t_d.dout = (s_xdata[i] && wide_bus) ? {s_byte[i], {BYTE_W{1'b0}}}
                                                        : {{BYTE_W{1'b0}}, s_byte[i]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_dout = t_q.dout;
    assign bus_doe  = t_q.doe;

endmodule

// File: rtl/gps_port_ctrl_chk.sv
module gps_port_ctrl_chk #(
    parameter int NUM_SOCK = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_iow_n,
    input logic                bus_ior_n,
    input logic                bus_doe,
    input logic [NUM_SOCK-1:0] gps_n,
    input logic [NUM_SOCK-1:0] gps_oe,
    input logic [NUM_SOCK-1:0] gps_pu_en
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~gps_n) <= 1); // R4

    AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> $past(!bus_ior_n)); // R9

    for (genvar i = 0; i < NUM_SOCK; i++) begin : g_pin
        AST_STROBE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gps_n[i]) |-> $past(!bus_iow_n || !bus_ior_n)); // R2

        AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            !gps_n[i] |-> gps_oe[i]); // R6

        AST_PULLUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            gps_pu_en[i] |-> (gps_n[i] && !gps_oe[i])); // R7
    end

endmodule

bind gps_port_ctrl gps_port_ctrl_chk #(.NUM_SOCK(NUM_SOCK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_iow_n (bus_iow_n),
    .bus_ior_n (bus_ior_n),
    .bus_doe   (bus_doe),
    .gps_n     (gps_n),
    .gps_oe    (gps_oe),
    .gps_pu_en (gps_pu_en)
);

// File: tb/gps_port_ctrl_test.sv
`timescale 1ns/1ps
module gps_port_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        iow_n = 1'b1;
    logic        ior_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        doe;
    logic        wide = 1'b0;
    logic [1:0]  pu_ctl = 2'b00;
    logic [1:0]  gps_n, gps_oe, gps_pu_en;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    gps_port_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (addr),
        .bus_iow_n   (iow_n),
        .bus_ior_n   (ior_n),
        .bus_din     (din),
        .bus_dout    (dout),
        .bus_doe     (doe),
        .wide_bus    (wide),
        .sock_pu_ctl (pu_ctl),
        .gps_n       (gps_n),
        .gps_oe      (gps_oe),
        .gps_pu_en   (gps_pu_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_port(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; din = d; iow_n = 1'b0;
        @(negedge clk); iow_n = 1'b1;
    endtask

    task automatic rd_port(input logic [9:0] a, output logic [15:0] d, output logic oe);
        @(negedge clk); addr = a; ior_n = 1'b0;
        @(negedge clk); d = dout; oe = doe; ior_n = 1'b1;
    endtask

    task automatic sel_reg(input int s, input logic [7:0] ext);
        logic [7:0] base;
        base = (s != 0) ? 8'h6E : 8'h2E;
        wr_port(10'h3E0, {8'h00, base});
        wr_port(10'h3E1, {8'h00, ext});
        wr_port(10'h3E0, {8'h00, base + 8'h01});
    endtask

    task automatic set_ctl(input int s, input logic [7:0] v);
        sel_reg(s, 8'h0B);
        wr_port(10'h3E1, {8'h00, v});
    endtask

    // Holds a command on the data port for len cycles, then 2 idle cycles
    task automatic pulse(input int s, input bit is_wr, input int len, input logic [15:0] d,
                         output int c_own, output int c_oth, output int c_oe, output int c_doe);
        c_own = 0; c_oth = 0; c_oe = 0; c_doe = 0;
        @(negedge clk); addr = 10'h3E1; din = d;
        if (is_wr) iow_n = 1'b0; else ior_n = 1'b0;
        for (int k = 0; k < len + 2; k++) begin
            @(negedge clk);
            if (k == len - 1) begin iow_n = 1'b1; ior_n = 1'b1; end
            if (!gps_n[s])     c_own++;
            if (!gps_n[1 - s]) c_oth++;
            if (gps_oe[s])     c_oe++;
            if (doe)           c_doe++;
        end
    endtask

    task automatic t_reset();
        logic [15:0] d; logic o;
        chk("R1 strobes idle", gps_n, 2'b11);
        chk("R1 pins undriven", gps_oe, 2'b00);
        chk("R1 pull-ups on", gps_pu_en, 2'b11);
        chk("R1 bus idle", doe, 0);
        rd_port(10'h3E0, d, o);
        chk("R1 index zero", d, 16'h0000);
        wr_port(10'h3E0, 16'h002F);
        rd_port(10'h3E1, d, o);
        chk("R1 window unselected", o, 0);
        sel_reg(0, 8'h0B);
        rd_port(10'h3E1, d, o);
        chk("R1 control zero", d, 16'h0000);
        sel_reg(1, 8'h0A);
        rd_port(10'h3E1, d, o);
        chk("R1 shadow zero", d, 16'h0000);
    endtask

    task automatic t_index();
        logic [15:0] d; logic o;
        wr_port(10'h3E0, 16'h006E);
        rd_port(10'h3E0, d, o);
        chk("R12 index readback", d, 16'h006E);
        chk("R12 index drives bus", o, 1);
        wr_port(10'h3E1, 16'h0033);
        rd_port(10'h3E1, d, o);
        chk("R12 ext index readback", d, 16'h0033);
    endtask

    task automatic t_reserved();
        logic [15:0] d; logic o;
        set_ctl(0, 8'hFF);
        rd_port(10'h3E1, d, o);
        chk("R8 reserved bits read 0", d, 16'h001C);
    endtask

    task automatic t_write();
        logic [15:0] d; logic o; int a, b, e, f;
        set_ctl(0, 8'h10);
        sel_reg(0, 8'h0A);
        pulse(0, 1'b1, 3, 16'h00C3, a, b, e, f);
        chk("R2 write strobe len 3", a, 3);
        chk("R4 other socket quiet", b, 0);
        pulse(0, 1'b1, 1, 16'h005A, a, b, e, f);
        chk("R2 write strobe len 1", a, 1);
        rd_port(10'h3E1, d, o);
        chk("R9 shadow readback", d, 16'h005A);
        chk("R9 shadow drives bus", o, 1);
    endtask

    task automatic t_read();
        int a, b, e, f;
        set_ctl(0, 8'h08);
        sel_reg(0, 8'h0A);
        pulse(0, 1'b0, 4, 16'h0000, a, b, e, f);
        chk("R3 read strobe len 4", a, 4);
        chk("R11 read released to buffer", f, 0);
    endtask

    task automatic t_none();
        logic [15:0] d; logic o; int a, b, e, f;
        set_ctl(1, 8'h00);
        sel_reg(1, 8'h0A);
        pulse(1, 1'b1, 2, 16'h0077, a, b, e, f);
        chk("R5 no write strobe", a, 0);
        pulse(1, 1'b0, 2, 16'h0000, a, b, e, f);
        chk("R5 no read strobe", a, 0);
        chk("R9 unconfigured read drives", f, 2);
        rd_port(10'h3E1, d, o);
        chk("R9 shadow of socket 1", d, 16'h0077);
    endtask

    task automatic t_wrongsel();
        int a, b, e, f;
        set_ctl(0, 8'h18);
        sel_reg(0, 8'h05);
        pulse(0, 1'b1, 2, 16'h0011, a, b, e, f);
        chk("R4 wrong ext index", a, 0);
        sel_reg(1, 8'h0A);
        pulse(1, 1'b1, 2, 16'h0022, a, b, e, f);
        chk("R4 socket 0 idle while 1 selected", b, 0);
    endtask

    task automatic t_mode();
        int a, b, e, f;
        set_ctl(0, 8'h10);
        sel_reg(0, 8'h0A);
        chk("R6 open-drain idle undriven", gps_oe[0], 0);
        pulse(0, 1'b1, 2, 16'h0044, a, b, e, f);
        chk("R6 open-drain drives only low", e, 2);
        set_ctl(0, 8'h14);
        chk("R6 push-pull driven idle", gps_oe[0], 1);
    endtask

    task automatic t_pullup();
        set_ctl(0, 8'h00);
        chk("R7 pull-up on unconfigured", gps_pu_en[0], 1);
        @(negedge clk); pu_ctl = 2'b01;
        @(negedge clk);
        chk("R7 pull-up off by control input", gps_pu_en[0], 0);
        pu_ctl = 2'b00;
        set_ctl(0, 8'h08);
        chk("R7 pull-up off read strobe", gps_pu_en[0], 0);
        set_ctl(0, 8'h10);
        chk("R7 pull-up off write strobe", gps_pu_en[0], 0);
    endtask

    task automatic t_lane();
        logic [15:0] d; logic o; int a, b, e, f;
        @(negedge clk); wide = 1'b1;
        set_ctl(0, 8'h10);
        sel_reg(0, 8'h0A);
        pulse(0, 1'b1, 1, 16'hA55A, a, b, e, f);
        rd_port(10'h3E1, d, o);
        chk("R10 high lane readback", d, 16'hA500);
        @(negedge clk); wide = 1'b0;
        rd_port(10'h3E1, d, o);
        chk("R10 low lane readback", d, 16'h00A5);
    endtask

    task automatic t_both();
        int a, b, e, f;
        set_ctl(0, 8'h18);
        sel_reg(0, 8'h0A);
        pulse(0, 1'b1, 2, 16'h0066, a, b, e, f);
        chk("R11 both: write strobe", a, 2);
        pulse(0, 1'b0, 2, 16'h0000, a, b, e, f);
        chk("R11 both: read strobe", a, 2);
        chk("R11 both: bus released", f, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_reserved();
        t_write();
        t_read();
        t_none();
        t_wrongsel();
        t_mode();
        t_pullup();
        t_lane();
        t_both();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule